// File: doc/BRIEF.md
# CAN Controller Interrupt Aggregator

This block gathers the status events of a CAN controller and turns them into four interrupt request lines. The lines are transmit, receive FIFO 0, receive FIFO 1, and status-change/error. The protocol engine, mailbox and FIFO storage, acceptance filtering and the error counters sit outside the block. They reach it as plain input signals:

- single-cycle event pulses;
- pending-message counts;
- error condition levels;
- a last-error code.

Events that must outlive their pulse are caught in sticky flags. Software clears a flag by writing a 1 to its bit, which arrives as a clear pulse. The flags are also brought out as outputs so that software can read them. Each source has its own enable input. The error-class sources (warning, passive, last-error code) also pass through a master error enable. Every interrupt line is a registered, active-high level. A line reflects an event on the clock edge that captures the event.

Top module: `can_irq_ctrl`

## Requirements
- R1: A pulse on `tx_done_i[m]` sets transmit flag `m` (`tx_flag_o[m]`, bit m for mailbox m). The flag stays at 1 until a pulse on `tx_clr_i[m]` clears it on the following edge.
- R2: After each edge, `irq_tx_o` is 1 exactly when some mailbox flag is 1 and its bit in `tx_en_i` is 1. The flag value used is the one just registered.
- R3: A non-zero pending count, with `rx_msg_en_i[f]` set, holds `irq_rx_o[f]` at 1 from the edge after the count appears. The line stays at 1 for as long as the count is non-zero, with no clear. FIFO f's count is `rx_count_i[2f+1:2f]`.
- R4: A pulse on `rx_full_evt_i[f]` sets sticky flag `rx_full_flag_o[f]`, and `rx_full_clr_i[f]` clears it. When `rx_full_en_i[f]` is 1, the flag drives `irq_rx_o[f]`.
- R5: A pulse on `rx_ovr_evt_i[f]` sets sticky flag `rx_ovr_flag_o[f]`, and `rx_ovr_clr_i[f]` clears it. When `rx_ovr_en_i[f]` is 1, the flag drives `irq_rx_o[f]`.
- R6: The two receive FIFOs are independent: inputs of one FIFO never change the flags or line of the other.
- R7: When a set event and a clear of the same flag occur in one cycle, the flag is 1 after the edge.
- R8: Sleep-entry and wake-up events set sticky flags, which have their own clear pulses. Through `sleep_en_i` and `wake_en_i` these flags drive `irq_sts_o` whatever the master error enable is.
- R9: The error-warning and error-passive levels drive `irq_sts_o` only when both their own enable and `err_master_en_i` are 1.
- R10: The last-error code drives `irq_sts_o` only when it is non-zero, `code_en_i` is 1 and `err_master_en_i` is 1. A code of 0 never raises the line.
- R11: In reset, all flags and interrupt lines are 0. Each line is a register that updates one edge after its inputs.
- R12: A disabled source still sets its flag but leaves its interrupt line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_done_i | input | 3 | Per-mailbox transmit-completed pulse |
| tx_clr_i | input | 3 | Per-mailbox write-one-to-clear pulse |
| tx_en_i | input | 3 | Per-mailbox transmit interrupt enable |
| rx_count_i | input | 4 | Pending message counts, 2 bits per FIFO, FIFO 0 in the low bits |
| rx_full_evt_i | input | 2 | Per-FIFO full event pulse |
| rx_ovr_evt_i | input | 2 | Per-FIFO overrun event pulse |
| rx_full_clr_i | input | 2 | Per-FIFO full flag clear pulse |
| rx_ovr_clr_i | input | 2 | Per-FIFO overrun flag clear pulse |
| rx_msg_en_i | input | 2 | Per-FIFO pending-message enable |
| rx_full_en_i | input | 2 | Per-FIFO full enable |
| rx_ovr_en_i | input | 2 | Per-FIFO overrun enable |
| sleep_evt_i | input | 1 | Sleep-mode entry pulse |
| wake_evt_i | input | 1 | Wake-up pulse |
| sleep_clr_i | input | 1 | Sleep flag clear pulse |
| wake_clr_i | input | 1 | Wake flag clear pulse |
| sleep_en_i | input | 1 | Sleep source enable |
| wake_en_i | input | 1 | Wake source enable |
| err_warn_i | input | 1 | Error-warning condition level |
| err_pass_i | input | 1 | Error-passive condition level |
| err_code_i | input | 3 | Last-error code, 0 means no error |
| warn_en_i | input | 1 | Error-warning enable |
| pass_en_i | input | 1 | Error-passive enable |
| code_en_i | input | 1 | Last-error code enable |
| err_master_en_i | input | 1 | Master enable for the error-class sources |
| tx_flag_o | output | 3 | Sticky transmit-completed flags |
| rx_full_flag_o | output | 2 | Sticky full flags |
| rx_ovr_flag_o | output | 2 | Sticky overrun flags |
| sleep_flag_o | output | 1 | Sticky sleep flag |
| wake_flag_o | output | 1 | Sticky wake flag |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_rx_o | output | 2 | Receive interrupts, bit f for FIFO f |
| irq_sts_o | output | 1 | Status-change/error interrupt |

## Verification
Some behaviour is checked by the assertions on every cycle:

- a set event forces its flag on the next edge, including when a clear arrives in the same cycle;
- a flag holds without a clear and drops after a clear alone;
- an enabled pending count raises its FIFO line;
- the status line stays low while the master enable and the sleep and wake enables are all off.

The bench covers what needs a scenario. That includes the exact OR of the enabled sources on each line, the independence of the two FIFOs, and a zero error code failing to raise the line. It also shows that a masked source leaves its flag visible.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
    localparam int MB_NUM   = 3;
    localparam int FIFO_NUM = 2;
    localparam int CNT_W    = 2;
    localparam int LEC_W    = 3;

    // Bit positions of the two status-change flags inside their shared bank
    localparam int STS_SLEEP = 0;
    localparam int STS_WAKE  = 1;
    localparam int STS_NUM   = 2;

    // Bit positions of the receive sticky flags inside one FIFO's bank
    localparam int RX_FULL = 0;
    localparam int RX_OVR  = 1;
    localparam int RX_NUM  = 2;

    typedef struct packed {
        logic irq;
    } line_state_t;
endpackage

// File: rtl/can_irq_sticky.sv
module can_irq_sticky #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o,
    output logic [W-1:0] flag_nxt_o
);
    typedef struct packed {
        logic [W-1:0] flags;
    } bank_t;

    bank_t st_d, st_q;

    // Set dominates a simultaneous clear
    always_comb begin
        st_d       = st_q;
        st_d.flags = set_i | (st_q.flags & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o     = st_q.flags;
    assign flag_nxt_o = st_d.flags;

    // Shared by the transmit, full, overrun, sleep and wake flags (R1, R4, R5, R8)
    for (genvar i = 0; i < W; i++) begin : g_chk
        a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_o[i]);
        a_r1_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
        a_r1_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
    end
endmodule

// File: rtl/can_irq_tx_unit.sv
module can_irq_tx_unit
    import can_irq_pkg::*;
#(
    parameter int NMB = MB_NUM
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NMB-1:0] done_i,
    input  logic [NMB-1:0] clr_i,
    input  logic [NMB-1:0] en_i,
    output logic [NMB-1:0] flag_o,
    output logic           irq_o
);
    logic [NMB-1:0] flag_nxt;
    line_state_t    ln_d, ln_q;

    can_irq_sticky #(.W(NMB)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (done_i),
        .clr_i     (clr_i),
        .flag_o    (flag_o),
        .flag_nxt_o(flag_nxt)
    );

    always_comb begin
        ln_d     = ln_q;
        ln_d.irq = |(flag_nxt & en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign irq_o = ln_q.irq;

    a_r2_enabled_done_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (|(done_i & en_i)) |=> irq_o);
    a_r12_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |=> !irq_o);
endmodule

// File: rtl/can_irq_rx_unit.sv
module can_irq_rx_unit
    import can_irq_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count_i,
    input  logic          full_evt_i,
    input  logic          ovr_evt_i,
    input  logic          full_clr_i,
    input  logic          ovr_clr_i,
    input  logic          msg_en_i,
    input  logic          full_en_i,
    input  logic          ovr_en_i,
    output logic          full_flag_o,
    output logic          ovr_flag_o,
    output logic          irq_o
);
    logic [RX_NUM-1:0] set_v, clr_v, flg, flg_nxt;
    line_state_t       ln_d, ln_q;

    always_comb begin
        set_v          = '0;
        clr_v          = '0;
        set_v[RX_FULL] = full_evt_i;
        set_v[RX_OVR]  = ovr_evt_i;
        clr_v[RX_FULL] = full_clr_i;
        clr_v[RX_OVR]  = ovr_clr_i;
    end

    can_irq_sticky #(.W(RX_NUM)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_v),
        .clr_i     (clr_v),
        .flag_o    (flg),
        .flag_nxt_o(flg_nxt)
    );

    // Pending count is a level source; full and overrun are sticky sources
    always_comb begin
        ln_d     = ln_q;
        ln_d.irq = ((count_i != '0) && msg_en_i)
                 | (flg_nxt[RX_FULL] & full_en_i)
                 | (flg_nxt[RX_OVR]  & ovr_en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign full_flag_o = flg[RX_FULL];
    assign ovr_flag_o  = flg[RX_OVR];
    assign irq_o       = ln_q.irq;

    a_r3_pending_level: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_i != '0) && msg_en_i) |=> irq_o);
    a_r4_full_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (full_evt_i && full_en_i) |=> irq_o);
    a_r5_ovr_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt_i && ovr_en_i) |=> irq_o);
    a_r12_rx_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_en_i && !full_en_i && !ovr_en_i) |=> !irq_o);
endmodule

// File: rtl/can_irq_sts_unit.sv
module can_irq_sts_unit
    import can_irq_pkg::*;
#(
    parameter int LW = LEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_evt_i,
    input  logic          wake_evt_i,
    input  logic          sleep_clr_i,
    input  logic          wake_clr_i,
    input  logic          sleep_en_i,
    input  logic          wake_en_i,
    input  logic          warn_i,
    input  logic          pass_i,
    input  logic [LW-1:0] code_i,
    input  logic          warn_en_i,
    input  logic          pass_en_i,
    input  logic          code_en_i,
    input  logic          master_en_i,
    output logic          sleep_flag_o,
    output logic          wake_flag_o,
    output logic          irq_o
);
    logic [STS_NUM-1:0] set_v, clr_v, flg, flg_nxt;
    logic               err_any;
    line_state_t        ln_d, ln_q;

    always_comb begin
        set_v            = '0;
        clr_v            = '0;
        set_v[STS_SLEEP] = sleep_evt_i;
        set_v[STS_WAKE]  = wake_evt_i;
        clr_v[STS_SLEEP] = sleep_clr_i;
        clr_v[STS_WAKE]  = wake_clr_i;
    end

    can_irq_sticky #(.W(STS_NUM)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_v),
        .clr_i     (clr_v),
        .flag_o    (flg),
        .flag_nxt_o(flg_nxt)
    );

    // Error-class sources share the master gate; state-change sources bypass it
    always_comb begin
        err_any  = (warn_i & warn_en_i)
                 | (pass_i & pass_en_i)
                 | ((code_i != '0) & code_en_i);
        ln_d     = ln_q;
        ln_d.irq = (flg_nxt[STS_SLEEP] & sleep_en_i)
                 | (flg_nxt[STS_WAKE]  & wake_en_i)
                 | (err_any & master_en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign sleep_flag_o = flg[STS_SLEEP];
    assign wake_flag_o  = flg[STS_WAKE];
    assign irq_o        = ln_q.irq;

    a_r8_sleep_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_evt_i && sleep_en_i) |=> irq_o);
    a_r8_wake_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_evt_i && wake_en_i) |=> irq_o);
    a_r9_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en_i && !sleep_en_i && !wake_en_i) |=> !irq_o);
    a_r10_zero_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_i == '0) && !warn_en_i && !pass_en_i && !sleep_en_i && !wake_en_i)
        |=> !irq_o);
endmodule

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
    import can_irq_pkg::*;
#(
    parameter int NMB = MB_NUM,
    parameter int NF  = FIFO_NUM,
    parameter int CW  = CNT_W,
    parameter int LW  = LEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NMB-1:0]    tx_done_i,
    input  logic [NMB-1:0]    tx_clr_i,
    input  logic [NMB-1:0]    tx_en_i,
    input  logic [NF*CW-1:0]  rx_count_i,
    input  logic [NF-1:0]     rx_full_evt_i,
    input  logic [NF-1:0]     rx_ovr_evt_i,
    input  logic [NF-1:0]     rx_full_clr_i,
    input  logic [NF-1:0]     rx_ovr_clr_i,
    input  logic [NF-1:0]     rx_msg_en_i,
    input  logic [NF-1:0]     rx_full_en_i,
    input  logic [NF-1:0]     rx_ovr_en_i,
    input  logic              sleep_evt_i,
    input  logic              wake_evt_i,
    input  logic              sleep_clr_i,
    input  logic              wake_clr_i,
    input  logic              sleep_en_i,
    input  logic              wake_en_i,
    input  logic              err_warn_i,
    input  logic              err_pass_i,
    input  logic [LW-1:0]     err_code_i,
    input  logic              warn_en_i,
    input  logic              pass_en_i,
    input  logic              code_en_i,
    input  logic              err_master_en_i,
    output logic [NMB-1:0]    tx_flag_o,
    output logic [NF-1:0]     rx_full_flag_o,
    output logic [NF-1:0]     rx_ovr_flag_o,
    output logic              sleep_flag_o,
    output logic              wake_flag_o,
    output logic              irq_tx_o,
    output logic [NF-1:0]     irq_rx_o,
    output logic              irq_sts_o
);
    can_irq_tx_unit #(.NMB(NMB)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .done_i(tx_done_i),
        .clr_i (tx_clr_i),
        .en_i  (tx_en_i),
        .flag_o(tx_flag_o),
        .irq_o (irq_tx_o)
    );

    for (genvar f = 0; f < NF; f++) begin : g_fifo
        can_irq_rx_unit #(.CW(CW)) u_rx (
            .clk        (clk),
            .rst_n      (rst_n),
            .count_i    (rx_count_i[f*CW +: CW]),
            .full_evt_i (rx_full_evt_i[f]),
            .ovr_evt_i  (rx_ovr_evt_i[f]),
            .full_clr_i (rx_full_clr_i[f]),
            .ovr_clr_i  (rx_ovr_clr_i[f]),
            .msg_en_i   (rx_msg_en_i[f]),
            .full_en_i  (rx_full_en_i[f]),
            .ovr_en_i   (rx_ovr_en_i[f]),
            .full_flag_o(rx_full_flag_o[f]),
            .ovr_flag_o (rx_ovr_flag_o[f]),
            .irq_o      (irq_rx_o[f])
        );
    end

    can_irq_sts_unit #(.LW(LW)) u_sts (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_evt_i (sleep_evt_i),
        .wake_evt_i  (wake_evt_i),
        .sleep_clr_i (sleep_clr_i),
        .wake_clr_i  (wake_clr_i),
        .sleep_en_i  (sleep_en_i),
        .wake_en_i   (wake_en_i),
        .warn_i      (err_warn_i),
        .pass_i      (err_pass_i),
        .code_i      (err_code_i),
        .warn_en_i   (warn_en_i),
        .pass_en_i   (pass_en_i),
        .code_en_i   (code_en_i),
        .master_en_i (err_master_en_i),
        .sleep_flag_o(sleep_flag_o),
        .wake_flag_o (wake_flag_o),
        .irq_o       (irq_sts_o)
    );

    // R11: every line is low while reset is held
    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!irq_tx_o && (irq_rx_o == '0) && !irq_sts_o));
endmodule

// File: tb/can_irq_ctrl_tb.sv
module can_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] tx_done, tx_clr, tx_en;
    logic [3:0] rx_count;
    logic [1:0] full_evt, ovr_evt, full_clr, ovr_clr, msg_en, full_en, ovr_en;
    logic       sleep_evt, wake_evt, sleep_clr, wake_clr, sleep_en, wake_en;
    logic       warn, pass;
    logic [2:0] code;
    logic       warn_en, pass_en, code_en, master_en;
    logic [2:0] tx_flag;
    logic [1:0] full_flag, ovr_flag, irq_rx;
    logic       sleep_flag, wake_flag, irq_tx, irq_sts;

    // Bench model
    logic [2:0] m_tx;
    logic [1:0] m_full, m_ovr, m_irq_rx;
    logic       m_sleep, m_wake, m_irq_tx, m_irq_sts;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_done_i(tx_done), .tx_clr_i(tx_clr), .tx_en_i(tx_en),
        .rx_count_i(rx_count), .rx_full_evt_i(full_evt), .rx_ovr_evt_i(ovr_evt),
        .rx_full_clr_i(full_clr), .rx_ovr_clr_i(ovr_clr),
        .rx_msg_en_i(msg_en), .rx_full_en_i(full_en), .rx_ovr_en_i(ovr_en),
        .sleep_evt_i(sleep_evt), .wake_evt_i(wake_evt),
        .sleep_clr_i(sleep_clr), .wake_clr_i(wake_clr),
        .sleep_en_i(sleep_en), .wake_en_i(wake_en),
        .err_warn_i(warn), .err_pass_i(pass), .err_code_i(code),
        .warn_en_i(warn_en), .pass_en_i(pass_en), .code_en_i(code_en),
        .err_master_en_i(master_en),
        .tx_flag_o(tx_flag), .rx_full_flag_o(full_flag), .rx_ovr_flag_o(ovr_flag),
        .sleep_flag_o(sleep_flag), .wake_flag_o(wake_flag),
        .irq_tx_o(irq_tx), .irq_rx_o(irq_rx), .irq_sts_o(irq_sts)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic sticky(input logic f, input logic s, input logic c);
        return s | (f & ~c);
    endfunction

    task automatic model_step();
        for (int m = 0; m < 3; m++) m_tx[m] = sticky(m_tx[m], tx_done[m], tx_clr[m]);
        for (int f = 0; f < 2; f++) begin
            m_full[f]   = sticky(m_full[f], full_evt[f], full_clr[f]);
            m_ovr[f]    = sticky(m_ovr[f], ovr_evt[f], ovr_clr[f]);
            m_irq_rx[f] = ((rx_count[f*2 +: 2] != 2'd0) & msg_en[f])
                        | (m_full[f] & full_en[f]) | (m_ovr[f] & ovr_en[f]);
        end
        m_sleep   = sticky(m_sleep, sleep_evt, sleep_clr);
        m_wake    = sticky(m_wake, wake_evt, wake_clr);
        m_irq_tx  = |(m_tx & tx_en);
        m_irq_sts = (m_sleep & sleep_en) | (m_wake & wake_en)
                  | (master_en & ((warn & warn_en) | (pass & pass_en)
                                  | ((code != 3'd0) & code_en)));
    endtask

    task automatic compare_all();
        check("R1", "tx_flag",    8'(tx_flag),    8'(m_tx));
        check("R2", "irq_tx",     8'(irq_tx),     8'(m_irq_tx));
        check("R3", "irq_rx",     8'(irq_rx),     8'(m_irq_rx));
        check("R4", "full_flag",  8'(full_flag),  8'(m_full));
        check("R5", "ovr_flag",   8'(ovr_flag),   8'(m_ovr));
        check("R8", "sleep_flag", 8'(sleep_flag), 8'(m_sleep));
        check("R8", "wake_flag",  8'(wake_flag),  8'(m_wake));
        check("R9", "irq_sts",    8'(irq_sts),    8'(m_irq_sts));
    endtask

    // Inputs already set; advance one edge and compare at the next falling edge
    task automatic step();
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic quiet_pulses();
        tx_done = '0; tx_clr = '0; full_evt = '0; ovr_evt = '0;
        full_clr = '0; ovr_clr = '0; sleep_evt = 0; wake_evt = 0;
        sleep_clr = 0; wake_clr = 0;
    endtask

    task automatic all_off();
        quiet_pulses();
        tx_en = '0; rx_count = '0; msg_en = '0; full_en = '0; ovr_en = '0;
        sleep_en = 0; wake_en = 0; warn = 0; pass = 0; code = '0;
        warn_en = 0; pass_en = 0; code_en = 0; master_en = 0;
    endtask

    task automatic clear_everything();
        all_off();
        tx_clr = '1; full_clr = '1; ovr_clr = '1; sleep_clr = 1; wake_clr = 1;
        step();
        quiet_pulses();
    endtask

    function automatic logic rbit(input int pct);
        return ($urandom_range(99) < pct);
    endfunction

    initial begin
        void'($urandom(32'h5EED_C0DE));
        all_off();
        m_tx = '0; m_full = '0; m_ovr = '0; m_irq_rx = '0;
        m_sleep = 0; m_wake = 0; m_irq_tx = 0; m_irq_sts = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "reset irq_tx",  8'(irq_tx),  8'h0);
        check("R11", "reset irq_rx",  8'(irq_rx),  8'h0);
        check("R11", "reset irq_sts", 8'(irq_sts), 8'h0);
        check("R11", "reset tx_flag", 8'(tx_flag), 8'h0);
        rst_n = 1;
        @(negedge clk);
        compare_all();

        // R7: set and clear together on mailbox 0, line enabled
        tx_en = 3'b001; tx_done = 3'b001; tx_clr = 3'b001;
        step();
        check("R7", "set beats clear", 8'(tx_flag[0]), 8'h1);
        quiet_pulses();
        tx_clr = 3'b001;
        step();
        check("R1", "w1c drops flag", 8'(tx_flag[0]), 8'h0);
        quiet_pulses();

        // R12: masked mailbox sets flag, line stays low
        tx_en = 3'b000; tx_done = 3'b100;
        step();
        check("R12", "masked flag set", 8'(tx_flag[2]), 8'h1);
        check("R12", "masked line low", 8'(irq_tx), 8'h0);
        quiet_pulses();
        tx_en = 3'b100;
        step();
        check("R2", "enable exposes held flag", 8'(irq_tx), 8'h1);
        clear_everything();

        // R3 and R6: count on FIFO 0 only, both FIFOs enabled; level held
        msg_en = 2'b11; rx_count = 4'b0010;
        step();
        check("R6", "fifo0 only", 8'(irq_rx), 8'h1);
        step();
        check("R3", "level holds", 8'(irq_rx[0]), 8'h1);
        rx_count = 4'b0000;
        step();
        check("R3", "count zero drops", 8'(irq_rx[0]), 8'h0);
        full_en = 2'b11; full_evt = 2'b10;
        step();
        check("R6", "fifo1 full only", 8'(irq_rx), 8'h2);
        check("R6", "fifo0 flag untouched", 8'(full_flag[0]), 8'h0);
        clear_everything();

        // R10: zero code never raises, non-zero does
        master_en = 1; code_en = 1; code = 3'd0;
        step();
        check("R10", "zero code quiet", 8'(irq_sts), 8'h0);
        code = 3'd5;
        step();
        check("R10", "nonzero code raises", 8'(irq_sts), 8'h1);

        // R9: master gate blocks error-class sources
        master_en = 0; warn = 1; warn_en = 1; pass = 1; pass_en = 1;
        step();
        check("R9", "master off blocks", 8'(irq_sts), 8'h0);

        // R8: sleep reaches the line with master off
        sleep_en = 1; sleep_evt = 1;
        step();
        check("R8", "sleep bypasses master", 8'(irq_sts), 8'h1);
        clear_everything();

        // Random traffic with sparse pulses and clears
        for (int i = 0; i < N_RANDOM; i++) begin
            for (int m = 0; m < 3; m++) begin
                tx_done[m] = rbit(15); tx_clr[m] = rbit(15); tx_en[m] = rbit(60);
            end
            rx_count = 4'($urandom_range(15));
            if (rbit(50)) rx_count = '0;
            for (int f = 0; f < 2; f++) begin
                full_evt[f] = rbit(10); ovr_evt[f] = rbit(10);
                full_clr[f] = rbit(15); ovr_clr[f] = rbit(15);
                msg_en[f] = rbit(50); full_en[f] = rbit(50); ovr_en[f] = rbit(50);
            end
            sleep_evt = rbit(10); wake_evt = rbit(10);
            sleep_clr = rbit(15); wake_clr = rbit(15);
            sleep_en = rbit(40); wake_en = rbit(40);
            warn = rbit(30); pass = rbit(30);
            code = rbit(50) ? 3'd0 : 3'($urandom_range(7));
            warn_en = rbit(40); pass_en = rbit(40); code_en = rbit(40);
            master_en = rbit(50);
            step();
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule